// File: doc/BRIEF.md
# DRAM Command Timing Legality Checker

This block sits beside the command scheduler of a DDR3-style memory controller and judges, every controller clock, whether one proposed command could go onto the bus in that cycle without breaking a programmed minimum spacing. The proposal is a command code and a bank index for a rank of eight banks. The block returns a combinational legal flag in the same cycle. When the scheduler really issues the command, it raises `cmd_issue`. A legal issued command then updates the block's history, and an illegal one changes nothing.

Each bank runs a small state machine with three states. `BK_IDLE` is the precharged state. `BK_OPEN` means a row is active. `BK_CLOSING` means a read or write with auto-precharge is waiting for its implicit precharge. The transitions are:
- `BK_IDLE` to `BK_OPEN` on an issued activate.
- `BK_OPEN` to `BK_IDLE` on an issued precharge.
- `BK_OPEN` to `BK_CLOSING` on an issued read or write while auto-precharge is on.
- `BK_CLOSING` to `BK_IDLE` in the first cycle in which an explicit precharge would have been legal.

Each bank also keeps saturating age counters: time since its activate, its precharge, its read and its write. Rank-wide, the block tracks the age of the last activate, the age of the last refresh, and the ages of the last four activates for the four-activate window. All spacings are input values in controller clocks.

Top module: `dram_timing_checker`

## Requirements
- R1: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5. NOP is always legal and codes 6 and 7 are never legal. After reset every bank is idle and every spacing counts as already satisfied, so an activate is legal at once.
- R2: Whatever the timers say, a read, write or precharge to a bank that is not open is illegal, and an activate to a bank that is not idle is illegal.
- R3: A read or write to an open bank becomes legal when the cycles elapsed since that bank's activate reach `t_rcd`. A command in the cycle of the issue counts 0 elapsed cycles, and the next cycle counts 1.
- R4: A precharge becomes legal only once `t_ras` cycles have elapsed since that bank's activate.
- R5: An activate to a bank needs `t_ras + t_rp` cycles since that bank's previous activate and `t_rp` cycles since its last precharge.
- R6: Any two activates in the rank are at least `t_rrd` cycles apart.
- R7: A new activate, when four earlier activates are on record, is legal only if the oldest of those four is at least `t_faw` cycles old.
- R8: A precharge to a bank needs `t_rtp` cycles since that bank's last read.
- R9: A precharge to a bank needs `t_wr_data + t_wr` cycles since that bank's last write. `t_wr_data` is the distance from the write command to its last data beat.
- R10: No activate is legal until `t_rfc` cycles after a refresh.
- R11: A refresh is legal only when all banks are idle.
- R12: With `auto_pre_en` high, an issued read or write puts the bank into `BK_CLOSING`. In that state all commands to the bank are illegal. The bank closes in the first cycle where R4, R8 and R9 hold, exactly as if a precharge had been issued in that cycle.
- R13: A command raised with `cmd_issue` while the flag is low leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 3 | Proposed command code |
| cmd_bank | input | 3 | Target bank index |
| cmd_issue | input | 1 | Proposed command is placed on the bus this cycle |
| auto_pre_en | input | 1 | Reads and writes carry auto-precharge |
| t_rcd | input | CW | Activate to read/write spacing |
| t_ras | input | CW | Activate to precharge spacing |
| t_rp | input | CW | Precharge to activate spacing |
| t_rrd | input | CW | Activate to activate spacing across banks |
| t_faw | input | CW | Four-activate window length |
| t_rtp | input | CW | Read to precharge spacing |
| t_wr | input | CW | Write recovery after last data |
| t_wr_data | input | CW | Write command to last data beat |
| t_rfc | input | CW | Refresh to activate spacing |
| cmd_legal | output | 1 | Proposed command is legal now |

## Verification
The checker module takes for granted four things about the inputs:
- the timing inputs are held steady while commands flow;
- every value is below the saturation limit of the CW-bit age counters;
- `cmd_bank` names an existing bank;
- `cmd_issue` signals only commands the scheduler has really placed on the bus.

The checker keeps its own activate and refresh ages, and its spacing assertions hold only under those conditions. The stimulus sets the timing values once before reset is released, keeps each one well below 63, addresses only banks 0 to 7, and changes command inputs only on the falling clock edge. It also probes many commands with `cmd_issue` low, so that legality is examined without the history changing.

// File: rtl/dram_chk_pkg.sv
package dram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

endpackage

// File: rtl/dram_age_ctr.sv
// Saturating elapsed-cycle counter: loads 1 on the edge that ends the event cycle.
module dram_age_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] age
);
    localparam logic [CW-1:0] AGE_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)              age <= AGE_MAX;
        else if (restart)        age <= CW'(1);
        else if (age != AGE_MAX) age <= age + CW'(1);
    end
endmodule

// File: rtl/dram_bank_fsm.sv
module dram_bank_fsm
    import dram_chk_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_act,
    input  logic          do_rd,
    input  logic          do_wr,
    input  logic          do_pre,
    input  logic          auto_pre_en,
    input  logic [CW-1:0] t_rcd,
    input  logic [CW-1:0] t_ras,
    input  logic [CW-1:0] t_rp,
    input  logic [CW-1:0] t_rtp,
    input  logic [CW-1:0] t_wr,
    input  logic [CW-1:0] t_wr_data,
    output logic          act_ok,
    output logic          rdwr_ok,
    output logic          pre_ok,
    output logic          is_idle
);
    bank_st_e      state, state_nxt;
    logic [CW-1:0] age_act, age_pre, age_rd, age_wr;
    logic [CW:0]   t_rc, t_wrec;
    logic          pre_timers_ok, close_evt;

    dram_age_ctr #(.CW(CW)) u_age_act (.clk(clk), .rst_n(rst_n), .restart(do_act),             .age(age_act));
    dram_age_ctr #(.CW(CW)) u_age_pre (.clk(clk), .rst_n(rst_n), .restart(do_pre | close_evt), .age(age_pre));
    dram_age_ctr #(.CW(CW)) u_age_rd  (.clk(clk), .rst_n(rst_n), .restart(do_rd),              .age(age_rd));
    dram_age_ctr #(.CW(CW)) u_age_wr  (.clk(clk), .rst_n(rst_n), .restart(do_wr),              .age(age_wr));

    assign t_rc   = {1'b0, t_ras} + {1'b0, t_rp};
    assign t_wrec = {1'b0, t_wr_data} + {1'b0, t_wr};

    assign pre_timers_ok = (age_act >= t_ras) && (age_rd >= t_rtp) && ({1'b0, age_wr} >= t_wrec);
    assign close_evt     = (state == BK_CLOSING) && pre_timers_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BK_IDLE;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            BK_IDLE:    if (do_act) state_nxt = BK_OPEN;
            BK_OPEN: begin
                if (do_pre)                                state_nxt = BK_IDLE;
                else if ((do_rd || do_wr) && auto_pre_en)  state_nxt = BK_CLOSING;
            end
            BK_CLOSING: if (pre_timers_ok) state_nxt = BK_IDLE;
            default:    state_nxt = BK_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        act_ok  = 1'b0;
        rdwr_ok = 1'b0;
        pre_ok  = 1'b0;
        is_idle = 1'b0;
        unique case (state)
            BK_IDLE: begin
                is_idle = 1'b1;
                act_ok  = (age_pre >= t_rp) && ({1'b0, age_act} >= t_rc);
            end
            BK_OPEN: begin
                rdwr_ok = (age_act >= t_rcd);
                pre_ok  = pre_timers_ok;
            end
            BK_CLOSING: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_rank_timer.sv
module dram_rank_timer #(
    parameter int CW       = 6,
    parameter int WIN_ACTS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_act,
    input  logic          do_ref,
    input  logic [CW-1:0] t_rrd,
    input  logic [CW-1:0] t_faw,
    input  logic [CW-1:0] t_rfc,
    output logic          act_ok
);
    localparam logic [CW-1:0] AGE_MAX = '1;

    logic [CW-1:0] age_last_act, age_ref;
    logic [CW-1:0] hist_age [WIN_ACTS];
    logic          hist_vld [WIN_ACTS];
    logic          faw_ok;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] a);
        return (a == AGE_MAX) ? a : a + CW'(1);
    endfunction

    dram_age_ctr #(.CW(CW)) u_age_act (.clk(clk), .rst_n(rst_n), .restart(do_act), .age(age_last_act));
    dram_age_ctr #(.CW(CW)) u_age_ref (.clk(clk), .rst_n(rst_n), .restart(do_ref), .age(age_ref));

    // Shift history of the most recent activates, newest in slot 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_age[0] <= AGE_MAX;
            hist_vld[0] <= 1'b0;
        end else if (do_act) begin
            hist_age[0] <= CW'(1);
            hist_vld[0] <= 1'b1;
        end else begin
            hist_age[0] <= sat_inc(hist_age[0]);
        end
    end

    for (genvar i = 1; i < WIN_ACTS; i++) begin : g_hist
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_age[i] <= AGE_MAX;
                hist_vld[i] <= 1'b0;
            end else if (do_act) begin
                hist_age[i] <= sat_inc(hist_age[i-1]);
                hist_vld[i] <= hist_vld[i-1];
            end else begin
                hist_age[i] <= sat_inc(hist_age[i]);
            end
        end
    end

    assign faw_ok = !hist_vld[WIN_ACTS-1] || (hist_age[WIN_ACTS-1] >= t_faw);
    assign act_ok = faw_ok && (age_last_act >= t_rrd) && (age_ref >= t_rfc);
endmodule

// File: rtl/dram_timing_checker.sv
module dram_timing_checker
    import dram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CW        = 6,
    parameter int BW        = $clog2(NUM_BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd_code,
    input  logic [BW-1:0] cmd_bank,
    input  logic          cmd_issue,
    input  logic          auto_pre_en,
    input  logic [CW-1:0] t_rcd,
    input  logic [CW-1:0] t_ras,
    input  logic [CW-1:0] t_rp,
    input  logic [CW-1:0] t_rrd,
    input  logic [CW-1:0] t_faw,
    input  logic [CW-1:0] t_rtp,
    input  logic [CW-1:0] t_wr,
    input  logic [CW-1:0] t_wr_data,
    input  logic [CW-1:0] t_rfc,
    output logic          cmd_legal
);
    logic [NUM_BANKS-1:0] bank_act_ok, bank_rdwr_ok, bank_pre_ok, bank_idle;
    logic                 rank_act_ok, take;

    assign take = cmd_issue && cmd_legal;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = take && (cmd_bank == BW'(b));
        dram_bank_fsm #(.CW(CW)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (hit && (cmd_code == CMD_ACT)),
            .do_rd      (hit && (cmd_code == CMD_RD)),
            .do_wr      (hit && (cmd_code == CMD_WR)),
            .do_pre     (hit && (cmd_code == CMD_PRE)),
            .auto_pre_en(auto_pre_en),
            .t_rcd      (t_rcd),
            .t_ras      (t_ras),
            .t_rp       (t_rp),
            .t_rtp      (t_rtp),
            .t_wr       (t_wr),
            .t_wr_data  (t_wr_data),
            .act_ok     (bank_act_ok[b]),
            .rdwr_ok    (bank_rdwr_ok[b]),
            .pre_ok     (bank_pre_ok[b]),
            .is_idle    (bank_idle[b])
        );
    end

    dram_rank_timer #(.CW(CW), .WIN_ACTS(4)) u_rank (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_act (take && (cmd_code == CMD_ACT)),
        .do_ref (take && (cmd_code == CMD_REF)),
        .t_rrd  (t_rrd),
        .t_faw  (t_faw),
        .t_rfc  (t_rfc),
        .act_ok (rank_act_ok)
    );

    always_comb begin
        cmd_legal = 1'b0;
        case (cmd_code)
            CMD_NOP: cmd_legal = 1'b1;
            CMD_ACT: cmd_legal = bank_act_ok[cmd_bank] && rank_act_ok;
            CMD_RD,
            CMD_WR:  cmd_legal = bank_rdwr_ok[cmd_bank];
            CMD_PRE: cmd_legal = bank_pre_ok[cmd_bank];
            CMD_REF: cmd_legal = &bank_idle;
            default: cmd_legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/dram_timing_checker_sva.sv
module dram_timing_checker_sva #(
    parameter int NUM_BANKS = 8,
    parameter int CW        = 6,
    parameter int BW        = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_code,
    input logic [BW-1:0]        cmd_bank,
    input logic                 cmd_issue,
    input logic                 cmd_legal,
    input logic [CW-1:0]        t_rcd,
    input logic [CW-1:0]        t_ras,
    input logic [CW-1:0]        t_rrd,
    input logic [CW-1:0]        t_rfc,
    input logic [NUM_BANKS-1:0] bank_idle
);
    localparam logic [CW-1:0] MAXV = '1;

    logic [CW-1:0] mon_act [NUM_BANKS];
    logic [CW-1:0] mon_any_act, mon_ref;
    logic          took;

    assign took = cmd_issue && cmd_legal;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_any_act <= MAXV;
            mon_ref     <= MAXV;
        end else begin
            if (took && cmd_code == 3'd1)  mon_any_act <= CW'(1);
            else if (mon_any_act != MAXV)  mon_any_act <= mon_any_act + CW'(1);
            if (took && cmd_code == 3'd5)  mon_ref <= CW'(1);
            else if (mon_ref != MAXV)      mon_ref <= mon_ref + CW'(1);
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mon
        always_ff @(posedge clk) begin
            if (!rst_n)                                            mon_act[b] <= MAXV;
            else if (took && cmd_code == 3'd1 && cmd_bank == BW'(b)) mon_act[b] <= CW'(1);
            else if (mon_act[b] != MAXV)                           mon_act[b] <= mon_act[b] + CW'(1);
        end
    end

    a_r1_nop_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 3'd0) |-> cmd_legal);
    a_r1_reserved_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code > 3'd5) |-> !cmd_legal);
    a_r2_rd_idle_bank: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == 3'd2) && bank_idle[cmd_bank]) |-> !cmd_legal);
    a_r3_rcd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == 3'd2 || cmd_code == 3'd3) && cmd_legal) |-> (mon_act[cmd_bank] >= t_rcd));
    a_r4_ras_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == 3'd4) && cmd_legal) |-> (mon_act[cmd_bank] >= t_ras));
    a_r6_rrd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == 3'd1) && cmd_legal) |-> (mon_any_act >= t_rrd));
    a_r10_rfc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == 3'd1) && cmd_legal) |-> (mon_ref >= t_rfc));
    a_r11_ref_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == 3'd5) && cmd_legal) |-> (&bank_idle));
endmodule

bind dram_timing_checker dram_timing_checker_sva #(
    .NUM_BANKS(NUM_BANKS), .CW(CW), .BW(BW)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .cmd_issue (cmd_issue),
    .cmd_legal (cmd_legal),
    .t_rcd     (t_rcd),
    .t_ras     (t_ras),
    .t_rrd     (t_rrd),
    .t_rfc     (t_rfc),
    .bank_idle (bank_idle)
);

// File: tb/dram_timing_checker_tb_top.sv
`timescale 1ns/1ps
module dram_timing_checker_tb_top;
    localparam int CW = 6;
    localparam int NV = 33;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic [2:0]    cmd_bank = 3'd0;
    logic          cmd_issue = 1'b0;
    logic          auto_pre_en = 1'b0;
    logic [CW-1:0] t_rcd = 6'd3, t_ras = 6'd6, t_rp = 6'd3, t_rrd = 6'd2, t_faw = 6'd16;
    logic [CW-1:0] t_rtp = 6'd2, t_wr = 6'd3, t_wr_data = 6'd4, t_rfc = 6'd8;
    logic          cmd_legal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dram_timing_checker #(.NUM_BANKS(8), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_issue(cmd_issue), .auto_pre_en(auto_pre_en),
        .t_rcd(t_rcd), .t_ras(t_ras), .t_rp(t_rp), .t_rrd(t_rrd), .t_faw(t_faw),
        .t_rtp(t_rtp), .t_wr(t_wr), .t_wr_data(t_wr_data), .t_rfc(t_rfc),
        .cmd_legal(cmd_legal)
    );

    // {code, bank, issue, expected, requirement}
    localparam logic [11:0] VEC [NV] = '{
        {3'd5, 3'd0, 1'b1, 1'b1, 4'd11}, // c0  REF all idle (R11)
        {3'd1, 3'd0, 1'b0, 1'b0, 4'd10}, // c1  ACT 1 after REF (R10)
        {3'd2, 3'd0, 1'b0, 1'b0, 4'd2},  // c2  RD idle bank (R2)
        {3'd4, 3'd1, 1'b0, 1'b0, 4'd2},  // c3  PRE idle bank (R2)
        {3'd0, 3'd0, 1'b0, 1'b1, 4'd1},  // c4  NOP (R1)
        {3'd0, 3'd0, 1'b0, 1'b1, 4'd1},  // c5
        {3'd6, 3'd0, 1'b0, 1'b0, 4'd1},  // c6  reserved (R1)
        {3'd1, 3'd0, 1'b0, 1'b0, 4'd10}, // c7  ACT 7 after REF (R10)
        {3'd1, 3'd0, 1'b1, 1'b1, 4'd10}, // c8  ACT b0 at boundary (R10)
        {3'd1, 3'd1, 1'b0, 1'b0, 4'd6},  // c9  ACT b1 1 after (R6)
        {3'd1, 3'd1, 1'b1, 1'b1, 4'd6},  // c10 ACT b1 at boundary (R6)
        {3'd2, 3'd0, 1'b1, 1'b1, 4'd3},  // c11 RD b0 at tRCD (R3)
        {3'd2, 3'd1, 1'b0, 1'b0, 4'd3},  // c12 RD b1 too early (R3)
        {3'd4, 3'd0, 1'b0, 1'b0, 4'd4},  // c13 PRE b0 before tRAS (R4)
        {3'd4, 3'd0, 1'b1, 1'b1, 4'd4},  // c14 PRE b0 at tRAS (R4)
        {3'd1, 3'd0, 1'b0, 1'b0, 4'd5},  // c15 ACT b0 inside tRP (R5)
        {3'd1, 3'd0, 1'b0, 1'b0, 4'd5},  // c16
        {3'd1, 3'd0, 1'b1, 1'b1, 4'd5},  // c17 ACT b0 at tRP/tRC (R5)
        {3'd3, 3'd1, 1'b1, 1'b1, 4'd3},  // c18 WR b1 (R3)
        {3'd1, 3'd2, 1'b1, 1'b1, 4'd6},  // c19 ACT b2, fourth in history (R6)
        {3'd4, 3'd1, 1'b0, 1'b0, 4'd9},  // c20 PRE b1 in write recovery (R9)
        {3'd1, 3'd3, 1'b0, 1'b0, 4'd7},  // c21 ACT b3 inside window (R7)
        {3'd2, 3'd2, 1'b0, 1'b1, 4'd3},  // c22 RD b2 probe (R3)
        {3'd0, 3'd0, 1'b0, 1'b1, 4'd1},  // c23
        {3'd1, 3'd3, 1'b1, 1'b1, 4'd7},  // c24 ACT b3 at window edge (R7)
        {3'd4, 3'd1, 1'b0, 1'b1, 4'd9},  // c25 PRE b1 at recovery edge (R9)
        {3'd5, 3'd0, 1'b0, 1'b0, 4'd11}, // c26 REF with open banks (R11)
        {3'd1, 3'd1, 1'b0, 1'b0, 4'd2},  // c27 ACT open bank (R2)
        {3'd2, 3'd0, 1'b0, 1'b1, 4'd3},  // c28 RD b0 probe (R3)
        {3'd2, 3'd2, 1'b1, 1'b1, 4'd3},  // c29 RD b2 (R3)
        {3'd4, 3'd2, 1'b0, 1'b0, 4'd8},  // c30 PRE b2 1 after RD (R8)
        {3'd4, 3'd2, 1'b1, 1'b1, 4'd8},  // c31 PRE b2 at tRTP (R8)
        {3'd2, 3'd2, 1'b0, 1'b0, 4'd2}   // c32 RD closed bank (R2)
    };

    task automatic step(input logic [2:0] c, input logic [2:0] b, input logic iss,
                        input logic exp, input string req);
        @(negedge clk);
        cmd_code  = c;
        cmd_bank  = b;
        cmd_issue = iss;
        #1;
        checks++;
        if (cmd_legal !== exp) begin
            errors++;
            $display("FAIL %s cmd=%0d bank=%0d actual=%b expected=%b", req, c, b, cmd_legal, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(3'd0, 3'd0, 1'b0, 1'b1, "R1");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_issue = 1'b0; cmd_code = 3'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11:9], VEC[i][8:6], VEC[i][5], VEC[i][4],
                 $sformatf("R%0d", VEC[i][3:0]));
        end

        // R1: reset state, mid-run
        do_reset();
        step(3'd2, 3'd0, 1'b0, 1'b0, "R1");
        step(3'd1, 3'd0, 1'b0, 1'b1, "R1");
        step(3'd5, 3'd0, 1'b0, 1'b1, "R1");

        // R13: illegal issued PRE is ignored, so no tRP block on the next ACT
        step(3'd4, 3'd5, 1'b1, 1'b0, "R13");
        step(3'd1, 3'd5, 1'b0, 1'b1, "R13");

        // R12: auto-precharge, ACT at t0, RD at t0+3, closes after cycle t0+6
        auto_pre_en = 1'b1;
        step(3'd1, 3'd4, 1'b1, 1'b1, "R12"); // t0
        idle(2);                               // t0+1, t0+2
        step(3'd2, 3'd4, 1'b1, 1'b1, "R12"); // t0+3
        step(3'd2, 3'd4, 1'b0, 1'b0, "R12"); // t0+4 closing
        step(3'd4, 3'd4, 1'b0, 1'b0, "R12"); // t0+5 closing
        step(3'd5, 3'd0, 1'b0, 1'b0, "R12"); // t0+6 still closing
        step(3'd5, 3'd0, 1'b0, 1'b1, "R12"); // t0+7 idle again
        step(3'd1, 3'd4, 1'b0, 1'b0, "R12"); // t0+8 tRP running
        step(3'd1, 3'd4, 1'b0, 1'b1, "R12"); // t0+9 reopen allowed
        auto_pre_en = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule